// File: doc/BRIEF.md
# Segment Access Limit Checker

This block decides whether a data access is legal for the cached descriptor of a segment. An access is given by its offset, its length in bytes (1 to 8) and its direction (read or write), together with the processor operating mode and the cached descriptor fields. These fields are the valid and present bits, the 4-bit type, the default-size bit and the scaled limit. One clock after the request, the block reports whether the access faults. When it faults, the block also gives the exception vector to raise.

The block also keeps two sticky flags for each segment, one for reads and one for writes. A flag is set when an access in that direction is cleared in a way that lets later accesses of the same direction take a cheaper path. Loading a new descriptor into a segment clears both of its flags. The segment being checked or reloaded is chosen by a select input. One select value is the stack segment, and this changes the exception vector.

Top module: `seg_access_chk`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `rsp_vector` are 0, and every bit of `rd_fast` and `wr_fast` is 0.
- R2: A request accepted while `req_valid` is 1 gives exactly one `rsp_valid` pulse on the next clock edge. `rsp_valid` is never 1 without a request in the previous cycle.
- R3: In 64-bit mode (`req_mode`=2), the only test is that offset bits 63..47 are all equal. The descriptor valid/present bits, type, limit and default-size bit have no effect. A passing access sets the segment's flag for its direction.
- R4: In protected mode (`req_mode`=1), an access to a descriptor whose valid bit or present bit is 0 faults.
- R5: In protected mode, a write is allowed only for types 2, 3, 6 and 7. Every other type faults on a write.
- R6: In protected mode, a read of type 8, 9, 12 or 13 faults. Reads of types 4 to 7 use the expand-down test. Reads of all other types use the normal limit test.
- R7: The normal limit test faults when length−1 exceeds the limit, or when the offset exceeds limit−(length−1).
- R8: The expand-down test uses an upper bound of 0xFFFFFFFF when the default-size bit is 1 and 0xFFFF when it is 0. It faults when the offset is at or below the limit, when the offset is above the upper bound, or when (upper bound − offset) is less than length−1.
- R9: Outside 64-bit mode, a segment's flag for the access direction is set only when the normal test passes and the limit is 7 or more. An expand-down pass or any fault leaves both flags unchanged, and a set flag stays set.
- R10: In real mode (`req_mode`=0), the normal limit test applies whatever the type, valid or present bits are.
- R11: `rsp_vector` is 12 for a faulting access to the stack segment (select value 2), 13 for a faulting access to any other segment, and 0 when there is no fault.
- R12: A pulse on `load_valid` clears both flags of the selected segment on the next edge and leaves the flags of every other segment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_mode | input | 2 | 0 real, 1 protected, 2 64-bit |
| seg_sel | input | 3 | Segment being checked or reloaded |
| desc_valid | input | 1 | Cached descriptor valid bit |
| desc_present | input | 1 | Cached descriptor present bit |
| desc_type | input | 4 | Cached descriptor type |
| desc_big | input | 1 | Default-size bit of the descriptor |
| seg_limit | input | 32 | Scaled segment limit |
| req_offset | input | 64 | Access offset |
| req_len | input | 4 | Access length in bytes, 1 to 8 |
| load_valid | input | 1 | New descriptor loaded into `seg_sel` |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Access faults |
| rsp_vector | output | 8 | Exception vector, 0 when no fault |
| rd_fast | output | 6 | Per-segment read fast-path flags |
| wr_fast | output | 6 | Per-segment write fast-path flags |

## Verification
The assertions assume that `load_valid` and `req_valid` are never 1 in the same cycle. They also assume that `req_len` stays in the range 1 to 8 and that `req_mode` never takes the reserved value 3. The stimulus meets these assumptions in three ways. Each task drives either a single request pulse or a single load pulse on its own negative edge and then returns both strobes to 0. Every length it uses is between 1 and 8. It only ever applies the three defined mode codes.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2
  } cpu_mode_e;

  typedef enum logic [1:0] {
    PATH_DENY = 2'd0,
    PATH_FLAT = 2'd1,
    PATH_DOWN = 2'd2,
    PATH_CANON = 2'd3
  } limit_path_e;

  localparam logic [7:0] VEC_STACK   = 8'd12;
  localparam logic [7:0] VEC_GENERAL = 8'd13;
  localparam logic [31:0] FAST_MIN_LIMIT = 32'd7;

  // Upper seventeen address bits must agree
  function automatic logic addr_canonical(input logic [63:0] addr);
    return (&addr[63:47]) | ~(|addr[63:47]);
  endfunction

  // Normal limit test: span is the last byte offset of the access
  function automatic logic flat_violation(input logic [63:0] off,
                                          input logic [31:0] lim,
                                          input logic [3:0]  len);
    logic [31:0] span;
    span = {28'd0, len} - 32'd1;
    if (span > lim) return 1'b1;
    return off > {32'd0, lim - span};
  endfunction

  // Expand-down test with a size-dependent ceiling
  function automatic logic down_violation(input logic [63:0] off,
                                          input logic [31:0] lim,
                                          input logic [3:0]  len,
                                          input logic        big);
    logic [63:0] ceil;
    logic [63:0] span;
    ceil = big ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_0000_FFFF;
    span = {60'd0, len} - 64'd1;
    if (off <= {32'd0, lim}) return 1'b1;
    if (off > ceil) return 1'b1;
    return (ceil - off) < span;
  endfunction

endpackage

// File: rtl/seg_chk_rules.sv
module seg_chk_rules
  import segchk_pkg::*;
(
  input  cpu_mode_e   mode,
  input  logic        is_write,
  input  logic        dvalid,
  input  logic        dpresent,
  input  logic [3:0]  dtype,
  input  logic        dbig,
  input  logic [31:0] limit,
  input  logic [63:0] offset,
  input  logic [3:0]  len,
  output limit_path_e path,
  output logic        fault,
  output logic        grant
);

  logic desc_usable;
  logic flat_bad;
  logic down_bad;
  logic canon_ok;

  assign desc_usable = dvalid & dpresent;
  assign flat_bad    = flat_violation(offset, limit, len);
  assign down_bad    = down_violation(offset, limit, len, dbig);
  assign canon_ok    = addr_canonical(offset);

  always_comb begin
    path = PATH_DENY;
    unique case (mode)
      MODE_LONG: path = PATH_CANON;
      MODE_REAL: path = PATH_FLAT;
      default: begin
        if (!desc_usable) begin
          path = PATH_DENY;
        end else if (is_write) begin
          unique case (dtype)
            4'd2, 4'd3: path = PATH_FLAT;
            4'd6, 4'd7: path = PATH_DOWN;
            default:    path = PATH_DENY;
          endcase
        end else begin
          unique case (dtype)
            4'd8, 4'd9, 4'd12, 4'd13: path = PATH_DENY;
            4'd4, 4'd5, 4'd6, 4'd7:   path = PATH_DOWN;
            default:                  path = PATH_FLAT;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    unique case (path)
      PATH_FLAT:  fault = flat_bad;
      PATH_DOWN:  fault = down_bad;
      PATH_CANON: fault = ~canon_ok;
      default:    fault = 1'b1;
    endcase
  end

  always_comb begin
    unique case (path)
      PATH_CANON: grant = canon_ok;
      PATH_FLAT:  grant = ~flat_bad & (limit >= FAST_MIN_LIMIT);
      default:    grant = 1'b0;
    endcase
  end

endmodule

// File: rtl/seg_chk_flags.sv
module seg_chk_flags #(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               set_write,
  input  logic               clr_en,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SEG-1:0] rd_ok,
  output logic [NUM_SEG-1:0] wr_ok
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = (sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_ok[g] <= 1'b0;
        wr_ok[g] <= 1'b0;
      end else if (clr_en && hit) begin
        rd_ok[g] <= 1'b0;
        wr_ok[g] <= 1'b0;
      end else if (set_en && hit) begin
        if (set_write) wr_ok[g] <= 1'b1;
        else           rd_ok[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import segchk_pkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int STACK_SEG = 2,
  localparam int SEL_W    = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_mode,
  input  logic [SEL_W-1:0]   seg_sel,
  input  logic               desc_valid,
  input  logic               desc_present,
  input  logic [3:0]         desc_type,
  input  logic               desc_big,
  input  logic [31:0]        seg_limit,
  input  logic [63:0]        req_offset,
  input  logic [3:0]         req_len,
  input  logic               load_valid,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [7:0]         rsp_vector,
  output logic [NUM_SEG-1:0] rd_fast,
  output logic [NUM_SEG-1:0] wr_fast
);

  cpu_mode_e   mode_q;
  limit_path_e chk_path;
  logic        chk_fault;
  logic        chk_grant;
  logic        fast_set;
  logic        stack_hit;
  logic [7:0]  vec_next;

  assign mode_q = cpu_mode_e'(req_mode);

  seg_chk_rules u_rules (
    .mode     (mode_q),
    .is_write (req_write),
    .dvalid   (desc_valid),
    .dpresent (desc_present),
    .dtype    (desc_type),
    .dbig     (desc_big),
    .limit    (seg_limit),
    .offset   (req_offset),
    .len      (req_len),
    .path     (chk_path),
    .fault    (chk_fault),
    .grant    (chk_grant)
  );

  assign fast_set  = req_valid & chk_grant;
  assign stack_hit = (seg_sel == SEL_W'(STACK_SEG));
  assign vec_next  = !chk_fault ? 8'd0 : (stack_hit ? VEC_STACK : VEC_GENERAL);

  seg_chk_flags #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (fast_set),
    .set_write (req_write),
    .clr_en    (load_valid),
    .sel       (seg_sel),
    .rd_ok     (rd_fast),
    .wr_ok     (wr_fast)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_vector <= 8'd0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_fault  <= req_valid & chk_fault;
      rsp_vector <= req_valid ? vec_next : 8'd0;
    end
  end

endmodule

// File: rtl/seg_access_chk_props.sv
module seg_access_chk_props
  import segchk_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_mode,
  input logic [SEL_W-1:0]   seg_sel,
  input logic               desc_valid,
  input logic               desc_present,
  input logic [3:0]         desc_type,
  input logic [63:0]        req_offset,
  input logic               load_valid,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [7:0]         rsp_vector,
  input logic [NUM_SEG-1:0] rd_fast,
  input logic [NUM_SEG-1:0] wr_fast
);

  p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  p_req_gets_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_vector_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault ? (rsp_vector == 8'd12 || rsp_vector == 8'd13)
                             : (rsp_vector == 8'd0)));

  p_canon_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd2 && addr_canonical(req_offset)) |=> !rsp_fault);

  p_unusable_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd1 && !(desc_valid && desc_present)) |=> rsp_fault);

  p_write_types_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_mode == 2'd1 &&
     !(desc_type inside {4'd2, 4'd3, 4'd6, 4'd7})) |=> rsp_fault);

  p_exec_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_mode == 2'd1 &&
     (desc_type inside {4'd8, 4'd9, 4'd12, 4'd13})) |=> rsp_fault);

  p_fault_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(load_valid)) |-> ($stable(rd_fast) && $stable(wr_fast)));

  p_load_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (!rd_fast[$past(seg_sel)] && !wr_fast[$past(seg_sel)]));

endmodule

bind seg_access_chk seg_access_chk_props #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_mode     (req_mode),
  .seg_sel      (seg_sel),
  .desc_valid   (desc_valid),
  .desc_present (desc_present),
  .desc_type    (desc_type),
  .req_offset   (req_offset),
  .load_valid   (load_valid),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_vector   (rsp_vector),
  .rd_fast      (rd_fast),
  .wr_fast      (wr_fast)
);

// File: tb/sim_seg_access_chk.sv
module sim_seg_access_chk;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [2:0]  seg_sel = 3'd0;
  logic        desc_valid = 1'b0;
  logic        desc_present = 1'b0;
  logic [3:0]  desc_type = 4'd0;
  logic        desc_big = 1'b0;
  logic [31:0] seg_limit = 32'd0;
  logic [63:0] req_offset = 64'd0;
  logic [3:0]  req_len = 4'd1;
  logic        load_valid = 1'b0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [7:0]  rsp_vector;
  logic [5:0]  rd_fast;
  logic [5:0]  wr_fast;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [5:0] exp_rd = '0;
  logic [5:0] exp_wr = '0;

  always #4 clk = ~clk;

  seg_access_chk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .seg_sel(seg_sel), .desc_valid(desc_valid),
    .desc_present(desc_present), .desc_type(desc_type), .desc_big(desc_big),
    .seg_limit(seg_limit), .req_offset(req_offset), .req_len(req_len),
    .load_valid(load_valid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_vector(rsp_vector), .rd_fast(rd_fast), .wr_fast(wr_fast)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One request pulse; results are sampled on the following negative edge
  task automatic access(input string tag, input logic wr, input logic [1:0] md,
                        input logic [2:0] seg, input logic v, input logic p,
                        input logic [3:0] ty, input logic big, input logic [31:0] lim,
                        input logic [63:0] off, input logic [3:0] len,
                        input logic exp_f, input logic exp_g);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mode = md; seg_sel = seg;
    desc_valid = v; desc_present = p; desc_type = ty; desc_big = big;
    seg_limit = lim; req_offset = off; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_g) begin
      if (wr) exp_wr[seg] = 1'b1;
      else    exp_rd[seg] = 1'b1;
    end
    check({tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " fault"}, 64'(rsp_fault), 64'(exp_f));
    check({tag, " R11 vector"}, 64'(rsp_vector),
          exp_f ? ((seg == 3'd2) ? 64'd12 : 64'd13) : 64'd0);
    check({tag, " R9 rd_fast"}, 64'(rd_fast), 64'(exp_rd));
    check({tag, " R9 wr_fast"}, 64'(wr_fast), 64'(exp_wr));
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 rsp_fault", 64'(rsp_fault), 64'd0);
    check("R1 rsp_vector", 64'(rsp_vector), 64'd0);
    check("R1 flags", 64'({rd_fast, wr_fast}), 64'd0);
  endtask

  task automatic t_normal_limit;
    access("R7 read last fit", 1'b0, 2'd1, 3'd0, 1, 1, 4'd2, 0, 32'hFF, 64'hF8, 4'd8, 0, 1);
    access("R7 read one past", 1'b0, 2'd1, 3'd0, 1, 1, 4'd2, 0, 32'hFF, 64'hF9, 4'd8, 1, 0);
    access("R7 len beyond limit", 1'b0, 2'd1, 3'd4, 1, 1, 4'd0, 0, 32'd3, 64'd0, 4'd8, 1, 0);
    access("R9 small limit pass", 1'b0, 2'd1, 3'd1, 1, 1, 4'd2, 0, 32'd5, 64'd4, 4'd2, 0, 0);
    access("R9 limit seven", 1'b0, 2'd1, 3'd5, 1, 1, 4'd0, 0, 32'd7, 64'd0, 4'd8, 0, 1);
  endtask

  task automatic t_types;
    access("R5 write read-only", 1'b1, 2'd1, 3'd1, 1, 1, 4'd0, 0, 32'hFFFF, 64'h10, 4'd2, 1, 0);
    access("R5 write code", 1'b1, 2'd1, 3'd1, 1, 1, 4'd10, 0, 32'hFFFF, 64'h10, 4'd2, 1, 0);
    access("R5 write data rw", 1'b1, 2'd1, 3'd1, 1, 1, 4'd3, 0, 32'hFFFF, 64'h10, 4'd2, 0, 1);
    access("R6 read exec-only", 1'b0, 2'd1, 3'd3, 1, 1, 4'd12, 0, 32'hFFFF, 64'h10, 4'd2, 1, 0);
    access("R6 read exec-read", 1'b0, 2'd1, 3'd3, 1, 1, 4'd10, 0, 32'hFFFF, 64'h10, 4'd2, 0, 1);
  endtask

  task automatic t_unusable;
    access("R4 invalid", 1'b0, 2'd1, 3'd4, 0, 1, 4'd2, 0, 32'hFFFF, 64'h10, 4'd1, 1, 0);
    access("R4 absent stack", 1'b0, 2'd1, 3'd2, 1, 0, 4'd2, 0, 32'hFFFF, 64'h10, 4'd1, 1, 0);
  endtask

  task automatic t_expand_down;
    access("R8 above limit", 1'b1, 2'd1, 3'd2, 1, 1, 4'd6, 0, 32'h0FFF, 64'h1000, 4'd4, 0, 0);
    access("R8 at limit", 1'b1, 2'd1, 3'd2, 1, 1, 4'd6, 0, 32'h0FFF, 64'h0FFF, 4'd4, 1, 0);
    access("R8 crosses top", 1'b0, 2'd1, 3'd2, 1, 1, 4'd5, 0, 32'h0FFF, 64'hFFFE, 4'd4, 1, 0);
    access("R8 ends at top", 1'b0, 2'd1, 3'd2, 1, 1, 4'd5, 0, 32'h0FFF, 64'hFFFC, 4'd4, 0, 0);
    access("R8 big ceiling", 1'b1, 2'd1, 3'd2, 1, 1, 4'd7, 1, 32'h0FFF, 64'h10000, 4'd4, 0, 0);
    access("R8 small ceiling", 1'b1, 2'd1, 3'd2, 1, 1, 4'd7, 0, 32'h0FFF, 64'h10000, 4'd4, 1, 0);
  endtask

  task automatic t_long_mode;
    access("R3 canonical low", 1'b1, 2'd2, 3'd4, 0, 0, 4'd8, 0, 32'd0, 64'h0000_7FFF_FFFF_FFF0, 4'd8, 0, 1);
    access("R3 bit47 stray", 1'b0, 2'd2, 3'd4, 1, 1, 4'd2, 0, 32'hFFFF_FFFF, 64'h0000_8000_0000_0000, 4'd1, 1, 0);
    access("R3 canonical high", 1'b0, 2'd2, 3'd2, 0, 0, 4'd12, 0, 32'd0, 64'hFFFF_8000_0000_0000, 4'd1, 0, 1);
    access("R3 stack noncanon", 1'b0, 2'd2, 3'd2, 1, 1, 4'd2, 0, 32'd0, 64'h0001_0000_0000_0000, 4'd1, 1, 0);
  endtask

  task automatic t_real_mode;
    access("R10 exec type ok", 1'b1, 2'd0, 3'd5, 0, 0, 4'd8, 0, 32'hFFFF, 64'h10, 4'd2, 0, 1);
    access("R10 past limit", 1'b0, 2'd0, 3'd1, 0, 0, 4'd8, 0, 32'hFFFF, 64'hFFFF, 4'd2, 1, 0);
  endtask

  task automatic t_load;
    @(negedge clk);
    load_valid = 1'b1; seg_sel = 3'd0;
    @(negedge clk);
    load_valid = 1'b0;
    exp_rd[0] = 1'b0; exp_wr[0] = 1'b0;
    check("R12 rd_fast after load", 64'(rd_fast), 64'(exp_rd));
    check("R12 wr_fast after load", 64'(wr_fast), 64'(exp_wr));
    check("R12 no response", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    load_valid = 1'b1; seg_sel = 3'd4;
    @(negedge clk);
    load_valid = 1'b0;
    exp_rd[4] = 1'b0; exp_wr[4] = 1'b0;
    check("R12 second load", 64'({rd_fast, wr_fast}), 64'({exp_rd, exp_wr}));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_limit();
    t_types();
    t_unusable();
    t_expand_down();
    t_long_mode();
    t_real_mode();
    t_load();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule